// File: doc/BRIEF.md
# K-State Stochastic Node Update Engine

This block updates a network of stochastic nodes in which every node sits in one of K states, kept as a K-bit one-hot code. An outside energy kernel supplies, for the node the engine is about to visit, an unsigned 16-bit flip probability. The engine reports that node's index on `node_idx_o`. On each update strobe the engine decides whether the addressed node stays or flips. Every node has its own two-state random decision unit for this. When the node flips, a single random selector shared by all nodes picks the new state uniformly from the K−1 states the node does not currently hold.

Nodes are visited one at a time, in increasing index order, one node per accepted strobe. After the last index the engine wraps to node 0. Each completed sweep steps an inverse-temperature value linearly from a programmed start towards a programmed end, and the kernel uses that value when it forms the next probabilities. The step that reaches the end raises a one-cycle done pulse. The supported state counts are K=3 and K=4, which serve three-way and four-way graph partitioning. Energy evaluation and graph handling belong to the kernel.

Top module: `kst_node_updater`

## Requirements
- R1: While reset is high and after its release, every node holds state 0 (one-hot value with only bit 0 set), `beta_o` equals `beta_first_i`, `node_idx_o` is 0, and `busy_o` and `done_o` are low.
- R2: Every reported update carries a one-hot `upd_state_o`, with bit i set meaning state i.
- R3: The flip decision compares the probability with a sample equal to the node's 16-bit LFSR value minus one (range 0..65534) and flips only when the sample is smaller. A probability of 0 therefore always leaves the node in its current state.
- R4: A probability of 65535 always flips the node, and the new state differs from the old one.
- R5: A flipped node lands on each of the other K−1 states with equal likelihood. When K−1 is not a power of two, out-of-range draws are rejected and redrawn, and the current state's index is skipped.
- R6: The fraction of updates that flip follows the probability, for example about one half at 32768 and about one quarter at 16384.
- R7: Updates address nodes 0, 1, …, N−1, 0, … in turn. `node_idx_o` always names the node that the next strobe will update.
- R8: Each time node N−1 is updated, `beta_o` grows by `beta_incr_i` in the same cycle as that update is reported.
- R9: A sweep step that would reach or pass `beta_last_i` sets `beta_o` to `beta_last_i` and raises `done_o` for exactly one cycle. Later sweeps change neither `beta_o` nor `done_o`.
- R10: A strobe that arrives while `busy_o` is high is ignored, so it produces no update and does not advance the node index.
- R11: A stay decision is reported with `upd_valid_o` high for one cycle, two clock edges after the edge that accepts the strobe (counting that edge as the first).
- R12: `states_o` holds node n at bits [n*K +: K]. An update changes only the addressed node's field, and that field equals the reported `upd_state_o`.
- R13: The block works for K=3 and for K=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_i | input | 1 | Update strobe; accepted only while not busy |
| flip_prob_i | input | 16 | Flip probability for the node named by `node_idx_o` |
| beta_first_i | input | 16 | Anneal start value, loaded at reset |
| beta_last_i | input | 16 | Anneal end value |
| beta_incr_i | input | 16 | Increment applied per completed sweep |
| node_idx_o | output | $clog2(N_NODES) | Node the next strobe updates |
| busy_o | output | 1 | An update is in progress |
| upd_valid_o | output | 1 | One-cycle pulse: an update was committed |
| upd_node_o | output | $clog2(N_NODES) | Index of the node just updated |
| upd_state_o | output | K_STATES | One-hot new state of that node |
| states_o | output | N_NODES*K_STATES | All node states, node n at bits [n*K +: K] |
| beta_o | output | 16 | Current inverse temperature |
| done_o | output | 1 | One-cycle pulse when the anneal reaches its end value |

## Verification
The bench builds two four-node copies side by side, one with K=3 and one with K=4. The K=4 copy is the only one that exercises the rejection path, because there K−1 is not a power of two. Four nodes keep each sweep to four updates, so the anneal reaches its end after three sweeps and the bench can see several sweeps past saturation. The run is also long enough to fill every from/to transition bin a few dozen times, which lets the equal-likelihood and flip-rate rules be checked against arithmetic bounds.

// File: rtl/kst_pkg.sv
package kst_pkg;

    localparam int RNG_W  = 16;
    localparam int BETA_W = 16;
    localparam logic [RNG_W-1:0] RNG_TAPS = 16'hB400;

    typedef logic [RNG_W-1:0]  rng_word_t;
    typedef logic [BETA_W-1:0] beta_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_PICK   = 2'd1,
        PH_COMMIT = 2'd2
    } phase_e;

    typedef struct packed {
        beta_t first;
        beta_t last;
        beta_t incr;
    } anneal_cfg_t;

    // Galois LFSR advanced by a fixed number of steps
    function automatic rng_word_t rng_advance(input rng_word_t s, input int unsigned steps);
        rng_word_t v;
        v = s;
        for (int unsigned i = 0; i < steps; i++) begin
            v = v[0] ? ((v >> 1) ^ RNG_TAPS) : (v >> 1);
        end
        return v;
    endfunction

    // Distinct nonzero seed per salt value
    function automatic rng_word_t rng_seed(input int unsigned salt);
        rng_word_t v;
        v = 16'hACE1 ^ rng_word_t'(salt * 32'd40503);
        if (v == '0) begin
            v = 16'h0001;
        end
        return v;
    endfunction

endpackage

// File: rtl/kst_flip_unit.sv
module kst_flip_unit
    import kst_pkg::*;
#(
    parameter rng_word_t SEED = 16'h0001
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      adv_i,
    input  rng_word_t prob_i,
    output logic      flip_o
);

    rng_word_t lfsr_q;
    rng_word_t sample;

    // A full word of fresh bits per use keeps successive samples independent
    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q <= SEED;
        end else if (adv_i) begin
            lfsr_q <= rng_advance(lfsr_q, RNG_W);
        end
    end

    // LFSR never holds zero, so the sample spans 0..65534
    assign sample = lfsr_q - rng_word_t'(1);
    assign flip_o = sample < prob_i;

endmodule

// File: rtl/kst_state_picker.sv
module kst_state_picker
    import kst_pkg::*;
#(
    parameter int        K_STATES = 3,
    parameter rng_word_t SEED     = 16'h0001,
    localparam int       K_W      = $clog2(K_STATES)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [K_W-1:0] cur_idx_i,
    output logic           valid_o,
    output logic [K_W-1:0] pick_idx_o
);

    localparam int SPAN      = K_STATES - 1;
    localparam int DRAW_W    = (SPAN > 1) ? $clog2(SPAN) : 1;
    localparam bit SPAN_POW2 = ((SPAN & (SPAN - 1)) == 0);

    rng_word_t      lfsr_q;
    logic [K_W-1:0] draw;

    // Free running; each cycle offers DRAW_W new bits
    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q <= SEED;
        end else begin
            lfsr_q <= rng_advance(lfsr_q, DRAW_W);
        end
    end

    assign draw = K_W'(lfsr_q[DRAW_W-1:0]);

    generate
        if (SPAN_POW2) begin : g_exact
            assign valid_o = 1'b1;
        end else begin : g_reject
            assign valid_o = (draw <= K_W'(SPAN - 1));
        end
    endgenerate

    // Map 0..K-2 onto the K-1 states that are not the current one
    assign pick_idx_o = (draw >= cur_idx_i) ? draw + K_W'(1) : draw;

endmodule

// File: rtl/kst_anneal_sched.sv
module kst_anneal_sched
    import kst_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  anneal_cfg_t cfg_i,
    input  logic        sweep_end_i,
    output beta_t       beta_o,
    output logic        done_o
);

    beta_t         beta_q;
    logic          finished_q;
    logic          done_q;
    logic [BETA_W:0] sum;
    logic          reach;

    assign sum   = {1'b0, beta_q} + {1'b0, cfg_i.incr};
    assign reach = sum >= {1'b0, cfg_i.last};

    always_ff @(posedge clk) begin
        if (rst) begin
            beta_q     <= cfg_i.first;
            finished_q <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (sweep_end_i && !finished_q) begin
                if (reach) begin
                    beta_q     <= cfg_i.last;
                    finished_q <= 1'b1;
                    done_q     <= 1'b1;
                end else begin
                    beta_q <= sum[BETA_W-1:0];
                end
            end
        end
    end

    assign beta_o = beta_q;
    assign done_o = done_q;

endmodule

// File: rtl/kst_node_updater.sv
module kst_node_updater
    import kst_pkg::*;
#(
    parameter int  N_NODES  = 8,
    parameter int  K_STATES = 3,
    localparam int NODE_W   = (N_NODES > 1) ? $clog2(N_NODES) : 1,
    localparam int K_W      = $clog2(K_STATES)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          upd_i,
    input  logic [15:0]                   flip_prob_i,
    input  logic [15:0]                   beta_first_i,
    input  logic [15:0]                   beta_last_i,
    input  logic [15:0]                   beta_incr_i,
    output logic [NODE_W-1:0]             node_idx_o,
    output logic                          busy_o,
    output logic                          upd_valid_o,
    output logic [NODE_W-1:0]             upd_node_o,
    output logic [K_STATES-1:0]           upd_state_o,
    output logic [N_NODES*K_STATES-1:0]   states_o,
    output logic [15:0]                   beta_o,
    output logic                          done_o
);

    typedef struct packed {
        logic [NODE_W-1:0]   node;
        logic [K_STATES-1:0] state;
    } upd_rec_t;

    localparam logic [NODE_W-1:0] LAST_NODE = NODE_W'(N_NODES - 1);

    phase_e              phase_q;
    logic [NODE_W-1:0]   node_q;
    logic [K_W-1:0]      target_q;
    upd_rec_t            rec_q;
    logic                valid_q;
    logic [K_STATES-1:0] st_q [N_NODES];

    logic [N_NODES-1:0]  flip_vec;
    logic [N_NODES-1:0]  adv_vec;
    logic [K_STATES-1:0] cur_oh;
    logic [K_W-1:0]      cur_idx;
    logic [K_STATES-1:0] target_oh;
    logic                pick_valid;
    logic [K_W-1:0]      pick_idx;
    logic                accept;
    logic                sweep_end;
    anneal_cfg_t         cfg;

    assign accept    = (phase_q == PH_IDLE) && upd_i;
    assign sweep_end = (phase_q == PH_COMMIT) && (node_q == LAST_NODE);
    assign cur_oh    = st_q[node_q];

    always_comb begin
        cur_idx = '0;
        for (int i = 0; i < K_STATES; i++) begin
            if (cur_oh[i]) begin
                cur_idx = K_W'(i);
            end
        end
    end

    always_comb begin
        target_oh = '0;
        for (int i = 0; i < K_STATES; i++) begin
            if (target_q == K_W'(i)) begin
                target_oh[i] = 1'b1;
            end
        end
    end

    // One two-state decision unit per node
    generate
        for (genvar g = 0; g < N_NODES; g++) begin : g_node
            assign adv_vec[g] = accept && (node_q == NODE_W'(g));
            kst_flip_unit #(
                .SEED(rng_seed(g + 1))
            ) u_flip (
                .clk    (clk),
                .rst    (rst),
                .adv_i  (adv_vec[g]),
                .prob_i (flip_prob_i),
                .flip_o (flip_vec[g])
            );
            assign states_o[g*K_STATES +: K_STATES] = st_q[g];
        end
    endgenerate

    // Single selector shared by all nodes
    kst_state_picker #(
        .K_STATES (K_STATES),
        .SEED     (rng_seed(N_NODES + 7))
    ) u_pick (
        .clk        (clk),
        .rst        (rst),
        .cur_idx_i  (cur_idx),
        .valid_o    (pick_valid),
        .pick_idx_o (pick_idx)
    );

    assign cfg = '{first: beta_first_i, last: beta_last_i, incr: beta_incr_i};

    kst_anneal_sched u_anneal (
        .clk         (clk),
        .rst         (rst),
        .cfg_i       (cfg),
        .sweep_end_i (sweep_end),
        .beta_o      (beta_o),
        .done_o      (done_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            node_q   <= '0;
            target_q <= '0;
            rec_q    <= '0;
            valid_q  <= 1'b0;
            for (int i = 0; i < N_NODES; i++) begin
                st_q[i] <= K_STATES'(1);
            end
        end else begin
            valid_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (upd_i) begin
                        if (flip_vec[node_q]) begin
                            phase_q <= PH_PICK;
                        end else begin
                            target_q <= cur_idx;
                            phase_q  <= PH_COMMIT;
                        end
                    end
                end
                PH_PICK: begin
                    if (pick_valid) begin
                        target_q <= pick_idx;
                        phase_q  <= PH_COMMIT;
                    end
                end
                PH_COMMIT: begin
                    for (int i = 0; i < N_NODES; i++) begin
                        if (node_q == NODE_W'(i)) begin
                            st_q[i] <= target_oh;
                        end
                    end
                    rec_q   <= '{node: node_q, state: target_oh};
                    valid_q <= 1'b1;
                    node_q  <= (node_q == LAST_NODE) ? '0 : node_q + NODE_W'(1);
                    phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign node_idx_o  = node_q;
    assign busy_o      = (phase_q != PH_IDLE);
    assign upd_valid_o = valid_q;
    assign upd_node_o  = rec_q.node;
    assign upd_state_o = rec_q.state;

endmodule

// File: rtl/kst_node_updater_chk.sv
module kst_node_updater_chk #(
    parameter int  N_NODES  = 8,
    parameter int  K_STATES = 3,
    localparam int NODE_W   = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        upd_i,
    input logic [15:0]                 flip_prob_i,
    input logic [15:0]                 beta_last_i,
    input logic [NODE_W-1:0]           node_idx_o,
    input logic                        busy_o,
    input logic                        upd_valid_o,
    input logic [NODE_W-1:0]           upd_node_o,
    input logic [K_STATES-1:0]         upd_state_o,
    input logic [N_NODES*K_STATES-1:0] states_o,
    input logic [15:0]                 beta_o,
    input logic                        done_o
);

    logic [K_STATES-1:0] cur_st;
    logic [K_STATES-1:0] upd_st;

    always_comb begin
        cur_st = '0;
        upd_st = '0;
        for (int i = 0; i < N_NODES; i++) begin
            if (node_idx_o == NODE_W'(i)) cur_st = states_o[i*K_STATES +: K_STATES];
            if (upd_node_o == NODE_W'(i)) upd_st = states_o[i*K_STATES +: K_STATES];
        end
    end

    a_r2_onehot_state: assert property (@(posedge clk) disable iff (rst)
        upd_valid_o |-> $onehot(upd_state_o));

    a_r12_field_matches: assert property (@(posedge clk) disable iff (rst)
        upd_valid_o |-> (upd_st == upd_state_o));

    a_r7_index_order: assert property (@(posedge clk) disable iff (rst)
        upd_valid_o |-> (node_idx_o == ((upd_node_o == NODE_W'(N_NODES - 1)) ? '0 : upd_node_o + NODE_W'(1))));

    a_r3_zero_prob_stays: assert property (@(posedge clk) disable iff (rst)
        (upd_i && !busy_o && flip_prob_i == 16'd0) |-> ##2 (upd_valid_o && upd_state_o == $past(cur_st, 2)));

    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (upd_i && !busy_o) |=> busy_o);

    a_r10_single_report: assert property (@(posedge clk) disable iff (rst)
        upd_valid_o |=> !upd_valid_o);

    a_r9_done_at_end: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (beta_o == beta_last_i));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r8_beta_moves_on_sweep: assert property (@(posedge clk) disable iff (rst)
        !$stable(beta_o) |-> (upd_valid_o && upd_node_o == NODE_W'(N_NODES - 1)));

endmodule

bind kst_node_updater kst_node_updater_chk #(
    .N_NODES  (N_NODES),
    .K_STATES (K_STATES)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .upd_i       (upd_i),
    .flip_prob_i (flip_prob_i),
    .beta_last_i (beta_last_i),
    .node_idx_o  (node_idx_o),
    .busy_o      (busy_o),
    .upd_valid_o (upd_valid_o),
    .upd_node_o  (upd_node_o),
    .upd_state_o (upd_state_o),
    .states_o    (states_o),
    .beta_o      (beta_o),
    .done_o      (done_o)
);

// File: tb/kst_node_updater_tb.sv
module kst_node_updater_tb_top;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst, upd;
    logic [15:0] prob, b_first, b_last, b_incr;

    logic [1:0]  a_nidx, a_unode;
    logic        a_busy, a_valid, a_done;
    logic [2:0]  a_ustate;
    logic [11:0] a_states;
    logic [15:0] a_beta;

    logic [1:0]  b_nidx, b_unode;
    logic        b_busy, b_valid, b_done;
    logic [3:0]  b_ustate;
    logic [15:0] b_states;
    logic [15:0] b_beta;

    kst_node_updater #(.N_NODES(4), .K_STATES(3)) dut_i (
        .clk(clk), .rst(rst), .upd_i(upd), .flip_prob_i(prob),
        .beta_first_i(b_first), .beta_last_i(b_last), .beta_incr_i(b_incr),
        .node_idx_o(a_nidx), .busy_o(a_busy), .upd_valid_o(a_valid),
        .upd_node_o(a_unode), .upd_state_o(a_ustate), .states_o(a_states),
        .beta_o(a_beta), .done_o(a_done));

    kst_node_updater #(.N_NODES(4), .K_STATES(4)) dut4_i (
        .clk(clk), .rst(rst), .upd_i(upd), .flip_prob_i(prob),
        .beta_first_i(b_first), .beta_last_i(b_last), .beta_incr_i(b_incr),
        .node_idx_o(b_nidx), .busy_o(b_busy), .upd_valid_o(b_valid),
        .upd_node_o(b_unode), .upd_state_o(b_ustate), .states_o(b_states),
        .beta_o(b_beta), .done_o(b_done));

    int errors = 0;
    int checks = 0;
    int model    [2][4];
    int exp_node [2];
    int exp_beta [2];
    bit reached  [2];
    int upd_cnt  [2];
    int flips    [2];
    int done_cnt [2];
    int trans    [2][4][4];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int oh_idx(input logic [3:0] v);
        for (int i = 0; i < 4; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic note_update(input int inst, input int node, input logic [3:0] st,
                               input logic [15:0] states, input logic [15:0] beta,
                               input logic done);
        int kk, newi, old, nxt;
        bit hit;
        logic [15:0] expv;
        kk = (inst == 1) ? 4 : 3;
        chk(node == exp_node[inst], (inst == 1) ? "R7 R13" : "R7", "node order", node, exp_node[inst]);
        exp_node[inst] = (exp_node[inst] + 1) % 4;
        chk($onehot(st), "R2", "one-hot state", st, 0);
        newi = oh_idx(st);
        old  = model[inst][node];
        if (prob == 16'd0) begin
            chk(newi == old, "R3", "zero probability keeps state", newi, old);
        end else if (prob == 16'hFFFF) begin
            chk(newi != old && newi >= 0 && newi < kk, "R4", "full probability flips", newi, old);
            if (newi >= 0 && newi < kk) trans[inst][old][newi]++;
        end else if (newi != old) begin
            flips[inst]++;
        end
        if (newi >= 0 && newi < kk) model[inst][node] = newi;
        expv = '0;
        for (int n = 0; n < 4; n++) expv = expv | (16'd1 << (n * kk + model[inst][n]));
        chk(states == expv, "R12", "state vector", states, expv);
        if (node == 3) begin
            hit = 1'b0;
            if (!reached[inst]) begin
                nxt = exp_beta[inst] + int'(b_incr);
                if (nxt >= int'(b_last)) begin
                    exp_beta[inst] = int'(b_last);
                    reached[inst] = 1'b1;
                    hit = 1'b1;
                end else begin
                    exp_beta[inst] = nxt;
                end
            end
            chk(int'(beta) == exp_beta[inst], "R8", "beta after sweep", beta, exp_beta[inst]);
            chk(done == hit, "R9", "done pulse at sweep end", done, hit);
        end
        upd_cnt[inst]++;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (a_valid) note_update(0, int'(a_unode), {1'b0, a_ustate}, {4'b0, a_states}, a_beta, a_done);
            if (b_valid) note_update(1, int'(b_unode), b_ustate, b_states, b_beta, b_done);
            if (a_done) done_cnt[0]++;
            if (b_done) done_cnt[1]++;
        end
    end

    task automatic do_update(input logic [15:0] p, input bit dbl);
        int guard;
        @(negedge clk);
        prob = p;
        upd  = 1'b1;
        @(negedge clk);
        if (!dbl) upd = 1'b0;
        @(negedge clk);
        upd = 1'b0;
        if (p == 16'd0)
            chk(a_valid && b_valid, "R11", "stay reported two edges after strobe", {a_valid, b_valid}, 3);
        guard = 0;
        while ((a_busy || b_busy) && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog all requirements: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int c0, c1, t, kk;
        rst = 1'b1; upd = 1'b0; prob = 16'd0;
        b_first = 16'd10; b_last = 16'd20; b_incr = 16'd4;
        for (int i = 0; i < 2; i++) begin
            exp_node[i] = 0; exp_beta[i] = 10; reached[i] = 1'b0;
            upd_cnt[i] = 0; flips[i] = 0; done_cnt[i] = 0;
            for (int n = 0; n < 4; n++) begin
                model[i][n] = 0;
                for (int m = 0; m < 4; m++) trans[i][n][m] = 0;
            end
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state, both state counts (R13)
        chk(a_states == 12'h249, "R1", "K3 states after reset", a_states, 12'h249);
        chk(b_states == 16'h1111, "R1 R13", "K4 states after reset", b_states, 16'h1111);
        chk(a_beta == 16'd10 && b_beta == 16'd10, "R1", "beta after reset", a_beta, 10);
        chk(!a_busy && !b_busy && !a_done && !b_done, "R1", "busy/done after reset",
            {a_busy, b_busy, a_done, b_done}, 0);
        chk(a_nidx == 2'd0 && b_nidx == 2'd0, "R1", "node index after reset", a_nidx, 0);

        // R3 two sweeps at zero probability; R8 beta 14 then 18
        for (int i = 0; i < 8; i++) do_update(16'd0, 1'b0);
        chk(a_beta == 16'd18 && b_beta == 16'd18, "R8", "beta after two sweeps", a_beta, 18);
        chk(done_cnt[0] == 0 && done_cnt[1] == 0, "R9", "no done before end", done_cnt[0], 0);

        // R10 strobe held over a busy cycle counts once
        c0 = upd_cnt[0]; c1 = upd_cnt[1];
        do_update(16'd0, 1'b1);
        chk(upd_cnt[0] == c0 + 1, "R10", "K3 updates from held strobe", upd_cnt[0] - c0, 1);
        chk(upd_cnt[1] == c1 + 1, "R10", "K4 updates from held strobe", upd_cnt[1] - c1, 1);
        chk(a_nidx == 2'd1 && b_nidx == 2'd1, "R10", "index after held strobe", a_nidx, 1);

        // R4/R9 finish sweep three at full probability: beta saturates at 20
        for (int i = 0; i < 3; i++) do_update(16'hFFFF, 1'b0);
        chk(done_cnt[0] == 1 && done_cnt[1] == 1, "R9", "one done pulse", done_cnt[0], 1);
        chk(a_beta == 16'd20 && b_beta == 16'd20, "R9", "beta at end", a_beta, 20);

        // R5 uniform pick among the other states
        for (int i = 0; i < 2; i++)
            for (int n = 0; n < 4; n++)
                for (int m = 0; m < 4; m++) trans[i][n][m] = 0;
        for (int i = 0; i < 600; i++) do_update(16'hFFFF, 1'b0);
        for (int i = 0; i < 2; i++) begin
            kk = (i == 1) ? 4 : 3;
            for (int f = 0; f < kk; f++) begin
                t = 0;
                for (int g = 0; g < kk; g++) t += trans[i][f][g];
                for (int g = 0; g < kk; g++) begin
                    if (g != f)
                        chk(trans[i][f][g] * (kk - 1) * 2 >= t && trans[i][f][g] * (kk - 1) * 2 <= 3 * t,
                            (i == 1) ? "R5 R13" : "R5", "transition count vs row total",
                            trans[i][f][g], t / (kk - 1));
                end
            end
        end
        chk(done_cnt[0] == 1 && done_cnt[1] == 1, "R9", "done stays single", done_cnt[1], 1);
        chk(a_beta == 16'd20 && b_beta == 16'd20, "R9", "beta held at end", b_beta, 20);

        // R6 flip rate tracks probability
        flips[0] = 0; flips[1] = 0;
        for (int i = 0; i < 400; i++) do_update(16'h8000, 1'b0);
        for (int i = 0; i < 2; i++)
            chk(flips[i] >= 140 && flips[i] <= 260, "R6", "flips of 400 at one half", flips[i], 200);
        flips[0] = 0; flips[1] = 0;
        for (int i = 0; i < 400; i++) do_update(16'h4000, 1'b0);
        for (int i = 0; i < 2; i++)
            chk(flips[i] >= 60 && flips[i] <= 140, "R6", "flips of 400 at one quarter", flips[i], 100);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule